// File: doc/BRIEF.md
# Edge-Triggered Interrupt Channel Bank

This block gathers eight external interrupt inputs into a single request for the CPU. Each input goes through a two-flop synchroniser and a registered copy of the synchronised value. A rising or a falling transition, chosen per channel, then sets that channel's pending latch. Software clears a latch by writing a one to its bit. A per-channel mask decides whether a pending latch may raise the CPU request. A 3-bit level per channel selects which unmasked pending channel is presented, and the lowest index wins a tie.

A serial-peripheral interrupt source is built in. Its transfer-done and mode-fault flags are ORed, gated by an enable bit and registered. When the source-select bit is set, this request replaces the external pin of channel `SPI_CH` (default 4). The channel detects edges, so the peripheral raises a new request only when the OR of its flags rises. If a flag is still high when software clears the pending bit, the channel stays quiet until both flags have dropped and one rises again.

Each channel runs a two-state machine. `CH_IDLE` moves to `CH_PEND` on a detected edge. `CH_PEND` stays in `CH_PEND` on a detected edge, even when a clear is written in the same cycle. `CH_PEND` returns to `CH_IDLE` on a clear write when there is no edge.

Top module: `eic_bank`

## Requirements
- R1: After reset every register reads 0, no channel is pending, and `irq_req` is 0.
- R2: If the trigger bit of a channel is 1 (register address 0, bit i = channel i), a low-to-high input transition sets its pending bit. The bit is readable 3 clock edges after the input changes. A high-to-low transition has no effect.
- R3: If the trigger bit is 0, a high-to-low transition sets the pending bit and a low-to-high transition has no effect.
- R4: Writing address 1 clears each pending bit whose data bit is 1. Bits written as 0 are unchanged. Reading address 1 returns the pending bits.
- R5: If a clear of a pending bit and a new edge on that channel land on the same clock edge, the pending bit stays set.
- R6: `irq_req` is 1 exactly when some channel is both pending and unmasked (address 2, bit i = 1 enables channel i). A masked pending bit stays readable.
- R7: `irq_chan` and `irq_level` give the unmasked pending channel with the highest level, and the lowest index wins a tie. The levels sit at addresses 3 to 6: channel 2p in data bits [2:0] and channel 2p+1 in bits [6:4] of address 3+p.
- R8: With the enable bit (address 7, bit 0) clear, the peripheral flags never set a pending bit.
- R9: With the select bit (address 7, bit 1) set, channel SPI_CH takes the peripheral request in place of its pin. With the bit clear it takes the pin and ignores the flags. The peripheral path is one cycle longer (4 edges).
- R10: The peripheral request is the OR of the done and fault flags. After its pending bit is cleared while that OR is high, no new pending occurs until both flags are low and one rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_irq | input | NCH | External interrupt inputs, asynchronous |
| spi_done | input | 1 | Peripheral transfer-done flag |
| spi_fault | input | 1 | Peripheral mode-fault flag |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | AW | Register address for both read and write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for `reg_addr`, combinational |
| irq_req | output | 1 | Request to the CPU |
| irq_chan | output | IW | Index of the winning channel |
| irq_level | output | PW | Level of the winning channel |

## Verification
The assertions check on every cycle that:
- a detected edge sets the pending state on the next edge, and that edge still wins against a clear in the same cycle;
- a clear with no edge empties the latch, and an idle latch never sets itself;
- the presented channel really is unmasked and pending, and no active channel outranks it;
- a disabled peripheral source never drives its request.

Only the bench scenarios can show what depends on the input sequence: the synchroniser latency, the choice of edge polarity, the source select, and the held-flag case where clearing the pending bit must not bring back a request until both flags have fallen.

// File: rtl/eic_pkg.sv
package eic_pkg;
    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_PEND = 1'b1
    } ch_state_t;

    localparam int unsigned REG_TRIG  = 0;
    localparam int unsigned REG_PEND  = 1;
    localparam int unsigned REG_MASK  = 2;
    localparam int unsigned REG_PRIO0 = 3;
endpackage

// File: rtl/eic_spi_src.sv
module eic_spi_src (
    input  logic clk,
    input  logic rst_n,
    input  logic done_flag,
    input  logic fault_flag,
    input  logic enable,
    output logic req
);
    logic req_q;

    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= enable & (done_flag | fault_flag);
    end

    assign req = req_q;

    // R8: a disabled source keeps its request low
    assert_disabled_quiet_R8: assert property (
        @(posedge clk) disable iff (!rst_n) !enable |=> !req);
endmodule

// File: rtl/eic_channel.sv
module eic_channel
    import eic_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic rise_sel,
    input  logic clr_req,
    output logic pend_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   cur;
    logic                   edge_hit;
    ch_state_t              state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign cur      = sync_q[SYNC_STAGES-1];
    assign edge_hit = rise_sel ? (cur & ~prev_q) : (~cur & prev_q);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: if (edge_hit) state_d = CH_PEND;
            CH_PEND: begin
                if (edge_hit)     state_d = CH_PEND;
                else if (clr_req) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        pend_o = (state_q == CH_PEND);
    end

    assert_edge_sets_pending_R2: assert property (
        @(posedge clk) disable iff (!rst_n) edge_hit |=> pend_o);

    assert_idle_holds_R2: assert property (
        @(posedge clk) disable iff (!rst_n) (!edge_hit && !pend_o) |=> !pend_o);

    assert_clear_empties_R4: assert property (
        @(posedge clk) disable iff (!rst_n) (clr_req && !edge_hit) |=> !pend_o);

    assert_edge_beats_clear_R5: assert property (
        @(posedge clk) disable iff (!rst_n) (clr_req && edge_hit) |=> pend_o);
endmodule

// File: rtl/eic_arbiter.sv
module eic_arbiter #(
    parameter int unsigned NCH = 8,
    parameter int unsigned PW  = 3,
    localparam int unsigned IW = $clog2(NCH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NCH-1:0]  active,
    input  logic [NCH*PW-1:0] levels,
    output logic            req,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   lvl
);
    logic          found;
    logic [IW-1:0] best_i;
    logic [PW-1:0] best_l;

    // linear scan; strict compare keeps the lowest index on a tie
    always_comb begin
        found  = 1'b0;
        best_i = '0;
        best_l = '0;
        for (int i = 0; i < NCH; i++) begin
            if (active[i] && (!found || levels[i*PW +: PW] > best_l)) begin
                found  = 1'b1;
                best_i = IW'(i);
                best_l = levels[i*PW +: PW];
            end
        end
    end

    assign req = found;
    assign idx = best_i;
    assign lvl = best_l;

    assert_req_is_active_R6: assert property (
        @(posedge clk) disable iff (!rst_n) req |-> active[idx]);

    always @(posedge clk) begin
        if (rst_n && req) begin
            for (int j = 0; j < NCH; j++) begin
                if (active[j]) begin
                    assert_winner_highest_R7: assert (levels[j*PW +: PW] <= lvl);
                    if (levels[j*PW +: PW] == lvl) begin
                        assert_tie_lowest_R7: assert (IW'(j) >= idx);
                    end
                end
            end
        end
    end
endmodule

// File: rtl/eic_bank.sv
module eic_bank
    import eic_pkg::*;
#(
    parameter int unsigned NCH         = 8,
    parameter int unsigned PW          = 3,
    parameter int unsigned DW          = 8,
    parameter int unsigned SPI_CH      = 4,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned IW       = $clog2(NCH),
    localparam int unsigned NPRIO    = NCH / 2,
    localparam int unsigned REG_CTRL = REG_PRIO0 + NPRIO,
    localparam int unsigned AW       = $clog2(REG_CTRL + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] ext_irq,
    input  logic           spi_done,
    input  logic           spi_fault,
    input  logic           reg_wr,
    input  logic [AW-1:0]  reg_addr,
    input  logic [DW-1:0]  reg_wdata,
    output logic [DW-1:0]  reg_rdata,
    output logic           irq_req,
    output logic [IW-1:0]  irq_chan,
    output logic [PW-1:0]  irq_level
);
    localparam logic [AW-1:0] A_TRIG = AW'(REG_TRIG);
    localparam logic [AW-1:0] A_PEND = AW'(REG_PEND);
    localparam logic [AW-1:0] A_MASK = AW'(REG_MASK);
    localparam logic [AW-1:0] A_CTRL = AW'(REG_CTRL);

    logic [NCH-1:0]    trig_q;
    logic [NCH-1:0]    mask_q;
    logic [NCH*PW-1:0] prio_q;
    logic              spi_en_q;
    logic              spi_sel_q;
    logic [NCH-1:0]    clr_vec;
    logic [NCH-1:0]    pend_vec;
    logic [NCH-1:0]    chan_in;
    logic              spi_req;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q    <= '0;
            mask_q    <= '0;
            prio_q    <= '0;
            spi_en_q  <= 1'b0;
            spi_sel_q <= 1'b0;
        end else if (reg_wr) begin
            if (reg_addr == A_TRIG) trig_q <= reg_wdata[NCH-1:0];
            if (reg_addr == A_MASK) mask_q <= reg_wdata[NCH-1:0];
            if (reg_addr == A_CTRL) begin
                spi_en_q  <= reg_wdata[0];
                spi_sel_q <= reg_wdata[1];
            end
            for (int p = 0; p < NPRIO; p++) begin
                if (reg_addr == AW'(REG_PRIO0 + p)) begin
                    prio_q[(2*p)*PW +: PW]   <= reg_wdata[PW-1:0];
                    prio_q[(2*p+1)*PW +: PW] <= reg_wdata[4 +: PW];
                end
            end
        end
    end

    assign clr_vec = (reg_wr && reg_addr == A_PEND) ? reg_wdata[NCH-1:0] : '0;

    // read mux
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_TRIG)      reg_rdata[NCH-1:0] = trig_q;
        else if (reg_addr == A_PEND) reg_rdata[NCH-1:0] = pend_vec;
        else if (reg_addr == A_MASK) reg_rdata[NCH-1:0] = mask_q;
        else if (reg_addr == A_CTRL) reg_rdata[1:0]     = {spi_sel_q, spi_en_q};
        for (int p = 0; p < NPRIO; p++) begin
            if (reg_addr == AW'(REG_PRIO0 + p)) begin
                reg_rdata[PW-1:0] = prio_q[(2*p)*PW +: PW];
                reg_rdata[4 +: PW] = prio_q[(2*p+1)*PW +: PW];
            end
        end
    end

    eic_spi_src u_spi (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_flag  (spi_done),
        .fault_flag (spi_fault),
        .enable     (spi_en_q),
        .req        (spi_req)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        if (g == SPI_CH) begin : g_mux
            assign chan_in[g] = spi_sel_q ? spi_req : ext_irq[g];
        end else begin : g_pin
            assign chan_in[g] = ext_irq[g];
        end

        eic_channel #(.SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_in   (chan_in[g]),
            .rise_sel (trig_q[g]),
            .clr_req  (clr_vec[g]),
            .pend_o   (pend_vec[g])
        );
    end

    eic_arbiter #(.NCH(NCH), .PW(PW)) u_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (pend_vec & mask_q),
        .levels (prio_q),
        .req    (irq_req),
        .idx    (irq_chan),
        .lvl    (irq_level)
    );
endmodule

// File: tb/tb_eic_bank.sv
`timescale 1ns/1ps
module tb_eic_bank;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] ext_irq = '0;
    logic       spi_done = 1'b0, spi_fault = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq_req;
    logic [2:0] irq_chan;
    logic [2:0] irq_level;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    eic_bank dut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
        .spi_done(spi_done), .spi_fault(spi_fault),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req),
        .irq_chan(irq_chan), .irq_level(irq_level)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic chk_reg(input string rq, input int a, input logic [7:0] exp);
        reg_addr = 3'(a);
        #1;
        chk(rq, reg_rdata, exp);
    endtask

    task automatic t_reset();
        for (int a = 0; a < 8; a++) chk_reg("R1 reg", a, 8'h00);
        chk("R1 irq_req", irq_req, 0);
    endtask

    task automatic t_rise();
        wr(0, 8'h04); wr(2, 8'hFF);
        ext_irq[2] = 1'b1; tick(2);
        chk_reg("R2 before latency", 1, 8'h00);
        tick(1);
        chk_reg("R2 rising sets", 1, 8'h04);
        chk("R2 irq_req", irq_req, 1);
        chk("R2 irq_chan", irq_chan, 2);
        ext_irq[2] = 1'b0; tick(3);
        chk_reg("R2 fall ignored", 1, 8'h04);
        wr(1, 8'h00);
        chk_reg("R4 zero write keeps", 1, 8'h04);
        wr(1, 8'h04);
        chk_reg("R4 clear", 1, 8'h00);
        chk("R4 irq_req low", irq_req, 0);
    endtask

    task automatic t_fall();
        ext_irq[3] = 1'b1; tick(3);
        chk_reg("R3 rise ignored", 1, 8'h00);
        ext_irq[3] = 1'b0; tick(3);
        chk_reg("R3 falling sets", 1, 8'h08);
        chk("R3 irq_chan", irq_chan, 3);
        wr(1, 8'h08);
    endtask

    task automatic t_mask();
        wr(0, 8'hFF); wr(2, 8'h00);
        ext_irq[1] = 1'b1; tick(3);
        chk_reg("R6 masked pend visible", 1, 8'h02);
        chk("R6 masked no req", irq_req, 0);
        wr(2, 8'h02);
        chk("R6 unmasked req", irq_req, 1);
        chk("R6 chan", irq_chan, 1);
        wr(1, 8'h02); ext_irq[1] = 1'b0; tick(3);
        wr(2, 8'hFF);
    endtask

    task automatic t_prio();
        ext_irq[3] = 1'b1; ext_irq[5] = 1'b1; tick(3);
        chk("R7 tie at zero", irq_chan, 3);
        wr(1, 8'h28); ext_irq[3] = 1'b0; ext_irq[5] = 1'b0; tick(3);
        wr(3, 8'h50); wr(5, 8'h02); wr(6, 8'h05);
        chk_reg("R7 prio readback", 3, 8'h50);
        ext_irq[1] = 1'b1; ext_irq[4] = 1'b1; ext_irq[6] = 1'b1; tick(3);
        chk("R7 tie lowest chan", irq_chan, 1);
        chk("R7 tie level", irq_level, 5);
        wr(6, 8'h07);
        chk_reg("R7 prio readback 6", 6, 8'h07);
        chk("R7 higher chan", irq_chan, 6);
        chk("R7 higher level", irq_level, 7);
        wr(1, 8'h40);
        chk("R7 after clear", irq_chan, 1);
        wr(1, 8'hFF);
        ext_irq = '0; tick(3);
        for (int a = 3; a < 7; a++) wr(a, 8'h00);
    endtask

    task automatic t_race();
        ext_irq[5] = 1'b1; tick(3);
        ext_irq[5] = 1'b0; tick(3);
        chk_reg("R5 preset", 1, 8'h20);
        ext_irq[5] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h20;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
        chk_reg("R5 edge beats clear", 1, 8'h20);
        wr(1, 8'h20);
        chk_reg("R5 later clear", 1, 8'h00);
        ext_irq[5] = 1'b0; tick(3);
    endtask

    task automatic t_spi();
        wr(7, 8'h02);
        spi_done = 1'b1; tick(4);
        chk_reg("R8 disabled", 1, 8'h00);
        spi_done = 1'b0; tick(4);
        wr(7, 8'h03);
        chk_reg("R9 ctrl readback", 7, 8'h03);
        spi_done = 1'b1; tick(4);
        chk_reg("R9 routed", 1, 8'h10);
        wr(1, 8'h10);
        spi_fault = 1'b1; tick(4);
        chk_reg("R10 second flag no req", 1, 8'h00);
        spi_done = 1'b0; tick(4);
        chk_reg("R10 one flag held", 1, 8'h00);
        spi_fault = 1'b0; tick(4);
        spi_fault = 1'b1; tick(4);
        chk_reg("R10 re-request", 1, 8'h10);
        wr(1, 8'h10); spi_fault = 1'b0; tick(4);
        wr(7, 8'h01);
        spi_done = 1'b1; tick(4);
        chk_reg("R9 flags ignored unselected", 1, 8'h00);
        ext_irq[4] = 1'b1; tick(3);
        chk_reg("R9 pin used", 1, 8'h10);
        ext_irq[4] = 1'b0; spi_done = 1'b0; wr(1, 8'h10);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_rise();
        t_fall();
        t_mask();
        t_prio();
        t_race();
        t_spi();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule